// File: doc/BRIEF.md
# Configurable Block Clock Generator

This block produces the four clock lines shared by one logic block of a programmable device. Each line draws its level from one of four global clock pins or, for the last line, from a product-term signal. Next to each level it drives an enable qualifier. Static configuration bits pick the sources, the active edge of line 1 and the enable sources. Line 3 is either the complement of line 2 or a product-term clock. It may only be a product-term clock while line 2 leaves its enable unused. The block flags the illegal combination and falls back to the complement.

The clock pins, product terms and enable input are sampled as data on a fast system clock. An edge on a line is found by comparing its level with the level in the previous cycle. Each line feeds a small test register. That register captures a data word only in a cycle where the line's chosen edge occurs while its enable is high. This makes every option visible cycle by cycle at the ports.

Top module: `blk_clkgen`

## Requirements
- R1: Configuration is stored from `cfg_i` on every clock edge while `cfg_load_i` is high and is held otherwise. No tick is flagged while `cfg_load_i` is high or in the cycle after it was sampled high. The layout is: line 0 source [1:0], line 1 source [3:2], line 1 edge mode [5:4], line 1 enable source [6], line 2 source [8:7], line 2 enable use [9], line 3 product-term request [10], line 3 product-term select [12:11].
- R2: Line 0 follows the global clock picked by bits [1:0]. Its enable is always 1 and it ticks on rising edges.
- R3: Line 1 follows the global clock picked by bits [3:2]. It ticks on rising edges for mode 0 and mode 3, on falling edges for mode 1, and on both edges for mode 2.
- R4: The enable of line 1 is the sampled `clk_en_i` when bit [6] is 0, and the sampled `pterm_i[0]` when bit [6] is 1.
- R5: Line 2 follows the global clock picked by bits [8:7] and ticks on rising edges. Its enable is the sampled `clk_en_i` when bit [9] is 1, and constant 1 otherwise.
- R6: In complement mode, line 3 is the inverse of line 2, carries line 2's enable and ticks on its own rising edges, which are the falling edges of line 2.
- R7: When bit [10] is 1 and bit [9] is 0, line 3 follows the sampled `pterm_i` bit picked by bits [12:11]. Its enable is then 1 and it ticks on rising edges.
- R8: When bits [10] and [9] are both 1, `cfg_err_o` is 1 and line 3 acts in complement mode. Otherwise `cfg_err_o` is 0.
- R9: Inputs are registered on each rising clock edge, and the line outputs show the registered values in the next cycle. A line ticks in a cycle where its level changed in the direction its mode asks for and its enable is high. At the following edge, that line's lane of `cap_o` (bits [4i+3:4i] for line i) takes `tst_data_i`. Otherwise the lane holds.
- R10: In reset, `cap_o` and `cfg_err_o` are 0, `line_lvl_o` is 4'b1000, `line_en_o` is 4'b1101 and `line_tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock that samples all inputs |
| rst_n | input | 1 | asynchronous active-low reset |
| gclk_i | input | 4 | global clock pin levels |
| pterm_i | input | 4 | product-term signals |
| clk_en_i | input | 1 | shared clock enable |
| cfg_load_i | input | 1 | configuration load strobe |
| cfg_i | input | 13 | configuration word |
| tst_data_i | input | 4 | data captured by the test registers |
| line_lvl_o | output | 4 | level of each block clock line |
| line_en_o | output | 4 | enable qualifier of each line |
| line_tick_o | output | 4 | qualified active edge of each line this cycle |
| cap_o | output | 16 | test register lanes, 4 bits per line |
| cfg_err_o | output | 1 | illegal line 3 request flagged |

## Verification
All 128 configurations are swept, with source selects rotated so each line picks a different pin. For each one, random pin, product-term and enable toggling runs while a cycle model predicts every level, enable, tick and captured lane. Random toggling on the pins, compared against the cycle model, separates rising, falling and both-edge capture on line 1, and separates complement mode from product-term mode on line 3. The enable sweep shows whether line 1 takes its enable from the shared input or from a product term. Changing `cfg_i` while the load strobe is low shows that the stored configuration is held. Running the illegal combination shows the error flag and the fallback to complement mode.

// File: rtl/blk_clkgen_pkg.sv
package blk_clkgen_pkg;
    localparam int NUM_GCLK = 4;
    localparam int NUM_PT   = 4;
    localparam int NUM_LINE = 4;
    localparam int GSEL_W   = $clog2(NUM_GCLK);
    localparam int PSEL_W   = $clog2(NUM_PT);
    localparam int PT_EN1   = 0;                 // product term used as line 1 enable
    localparam int LINE_CMP = NUM_LINE - 1;      // complement / product-term line

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSV  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic [PSEL_W-1:0] pt3_sel;
        logic              l3_pt;
        logic              en2_use;
        logic [GSEL_W-1:0] sel2;
        logic              en1_pt;
        edge_mode_e        mode1;
        logic [GSEL_W-1:0] sel1;
        logic [GSEL_W-1:0] sel0;
    } blk_cfg_t;

    localparam int CFG_W = $bits(blk_cfg_t);
endpackage

// File: rtl/clkgen_cfg_reg.sv
module clkgen_cfg_reg
    import blk_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_i,
    output blk_cfg_t         cfg_o,
    output logic             hold_o,
    output logic             err_o
);
    typedef struct packed {
        blk_cfg_t cfg;
        logic     ld;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ld = load_i;
        if (load_i) begin
            st_d.cfg = blk_cfg_t'(cfg_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign hold_o = load_i | st_q.ld;
    assign err_o  = st_q.cfg.l3_pt & st_q.cfg.en2_use;
endmodule

// File: rtl/clkgen_line_mux.sv
module clkgen_line_mux
    import blk_clkgen_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GCLK-1:0]        gclk_i,
    input  logic [NUM_PT-1:0]          pterm_i,
    input  logic                       en_i,
    input  blk_cfg_t                   cfg_i,
    output logic [NUM_LINE-1:0]        lvl_o,
    output logic [NUM_LINE-1:0]        en_o,
    output edge_mode_e [NUM_LINE-1:0]  mode_o
);
    typedef struct packed {
        logic [NUM_GCLK-1:0] g;
        logic [NUM_PT-1:0]   pt;
        logic                en;
    } samp_t;

    samp_t samp_d, samp_q;
    logic  pt_clk;
    logic  l2_lvl;
    logic  l2_en;

    always_comb begin
        samp_d.g  = gclk_i;
        samp_d.pt = pterm_i;
        samp_d.en = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    always_comb begin
        pt_clk = cfg_i.l3_pt & ~cfg_i.en2_use;
        l2_lvl = samp_q.g[cfg_i.sel2];
        l2_en  = cfg_i.en2_use ? samp_q.en : 1'b1;

        lvl_o[0] = samp_q.g[cfg_i.sel0];
        lvl_o[1] = samp_q.g[cfg_i.sel1];
        lvl_o[2] = l2_lvl;
        lvl_o[LINE_CMP] = pt_clk ? samp_q.pt[cfg_i.pt3_sel] : ~l2_lvl;

        en_o[0] = 1'b1;
        en_o[1] = cfg_i.en1_pt ? samp_q.pt[PT_EN1] : samp_q.en;
        en_o[2] = l2_en;
        en_o[LINE_CMP] = pt_clk ? 1'b1 : l2_en;

        for (int i = 0; i < NUM_LINE; i++) begin
            mode_o[i] = EDGE_RISE;
        end
        mode_o[1] = cfg_i.mode1;
    end
endmodule

// File: rtl/clkgen_edge_cap.sv
module clkgen_edge_cap
    import blk_clkgen_pkg::*;
#(
    parameter int   DW      = 4,
    parameter logic RST_LVL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic          en_i,
    input  edge_mode_e    mode_i,
    input  logic          hold_i,
    input  logic [DW-1:0] data_i,
    output logic          tick_o,
    output logic [DW-1:0] cap_o
);
    typedef struct packed {
        logic          prev;
        logic [DW-1:0] cap;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    rise, fall, hit;

    always_comb begin
        rise = lvl_i & ~st_q.prev;
        fall = ~lvl_i & st_q.prev;
        case (mode_i)
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = rise;
        endcase
        tick_o    = hit & en_i & ~hold_i;
        st_d      = st_q;
        st_d.prev = lvl_i;
        if (tick_o) begin
            st_d.cap = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= RST_LVL;
            st_q.cap  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o = st_q.cap;
endmodule

// File: rtl/blk_clkgen.sv
module blk_clkgen
    import blk_clkgen_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_GCLK-1:0]    gclk_i,
    input  logic [NUM_PT-1:0]      pterm_i,
    input  logic                   clk_en_i,
    input  logic                   cfg_load_i,
    input  logic [CFG_W-1:0]       cfg_i,
    input  logic [DW-1:0]          tst_data_i,
    output logic [NUM_LINE-1:0]    line_lvl_o,
    output logic [NUM_LINE-1:0]    line_en_o,
    output logic [NUM_LINE-1:0]    line_tick_o,
    output logic [NUM_LINE*DW-1:0] cap_o,
    output logic                   cfg_err_o
);
    // reset levels: every source samples low, so only the complement line is high
    localparam logic [NUM_LINE-1:0] RST_LVLS = NUM_LINE'(1) << LINE_CMP;

    blk_cfg_t                  cfg_q;
    logic                      hold;
    edge_mode_e [NUM_LINE-1:0] line_mode;

    clkgen_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load_i),
        .cfg_i  (cfg_i),
        .cfg_o  (cfg_q),
        .hold_o (hold),
        .err_o  (cfg_err_o)
    );

    clkgen_line_mux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .gclk_i  (gclk_i),
        .pterm_i (pterm_i),
        .en_i    (clk_en_i),
        .cfg_i   (cfg_q),
        .lvl_o   (line_lvl_o),
        .en_o    (line_en_o),
        .mode_o  (line_mode)
    );

    for (genvar i = 0; i < NUM_LINE; i++) begin : g_line
        clkgen_edge_cap #(
            .DW      (DW),
            .RST_LVL (RST_LVLS[i])
        ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (line_lvl_o[i]),
            .en_i   (line_en_o[i]),
            .mode_i (line_mode[i]),
            .hold_i (hold),
            .data_i (tst_data_i),
            .tick_o (line_tick_o[i]),
            .cap_o  (cap_o[i*DW +: DW])
        );
    end
endmodule

// File: rtl/blk_clkgen_chk.sv
module blk_clkgen_chk
    import blk_clkgen_pkg::*;
#(
    parameter int DW = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_load_i,
    input logic [CFG_W-1:0]       cfg_i,
    input blk_cfg_t               cfg_q,
    input logic [NUM_LINE-1:0]    line_lvl_o,
    input logic [NUM_LINE-1:0]    line_en_o,
    input logic [NUM_LINE-1:0]    line_tick_o,
    input logic [NUM_LINE*DW-1:0] cap_o,
    input logic                   cfg_err_o
);
    blk_cfg_t new_cfg;
    logic     new_bad;
    logic     cmp_mode;
    logic     armed_q;
    logic     unused_cfg;

    assign new_cfg    = blk_cfg_t'(cfg_i);
    assign new_bad    = new_cfg.l3_pt & new_cfg.en2_use;
    assign cmp_mode   = ~cfg_q.l3_pt | cfg_q.en2_use;
    assign unused_cfg = ^{new_cfg, cfg_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |-> (line_tick_o == '0)) else $error("load tick"); // R1

    AST_L0_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick_o[0] |-> line_lvl_o[0]) else $error("line0 edge"); // R2

    AST_L1_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode1 == EDGE_FALL && line_tick_o[1]) |-> !line_lvl_o[1]) else $error("line1 fall"); // R3

    AST_L2_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick_o[2] |-> line_lvl_o[2]) else $error("line2 edge"); // R5

    AST_L3_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_mode |-> (line_lvl_o[LINE_CMP] != line_lvl_o[2] && line_en_o[LINE_CMP] == line_en_o[2]))
        else $error("complement line"); // R6

    AST_L3_PT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_mode |-> line_en_o[LINE_CMP]) else $error("pt line enable"); // R7

    AST_ERR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cfg_load_i) && $past(new_bad)) |-> cfg_err_o) else $error("no error flag"); // R8

    AST_TICK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick_o & ~line_en_o) == '0) else $error("tick without enable"); // R9

    for (genvar i = 0; i < NUM_LINE; i++) begin : g_hold
        AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && !line_tick_o[i]) |=> $stable(cap_o[i*DW +: DW])) else $error("lane moved"); // R9
    end
endmodule

bind blk_clkgen blk_clkgen_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_i  (cfg_load_i),
    .cfg_i       (cfg_i),
    .cfg_q       (cfg_q),
    .line_lvl_o  (line_lvl_o),
    .line_en_o   (line_en_o),
    .line_tick_o (line_tick_o),
    .cap_o       (cap_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_blk_clkgen.sv
`timescale 1ns/1ps
module sim_blk_clkgen;
    import blk_clkgen_pkg::*;
    localparam int DW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        gclk_i = '0;
    logic [3:0]        pterm_i = '0;
    logic              clk_en_i = 1'b0;
    logic              cfg_load_i = 1'b0;
    logic [12:0]       cfg_i = '0;
    logic [DW-1:0]     tst_data_i = '0;
    logic [3:0]        line_lvl_o, line_en_o, line_tick_o;
    logic [4*DW-1:0]   cap_o;
    logic              cfg_err_o;

    always #2 clk = ~clk;

    blk_clkgen #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .gclk_i(gclk_i), .pterm_i(pterm_i),
        .clk_en_i(clk_en_i), .cfg_load_i(cfg_load_i), .cfg_i(cfg_i),
        .tst_data_i(tst_data_i), .line_lvl_o(line_lvl_o), .line_en_o(line_en_o),
        .line_tick_o(line_tick_o), .cap_o(cap_o), .cfg_err_o(cfg_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // cycle model built from the requirements
    logic [12:0]     m_cfg;
    logic [3:0]      m_g, m_pt, m_prev;
    logic            m_en, m_ld;
    logic [4*DW-1:0] m_cap;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pt_mode();
        return m_cfg[10] & ~m_cfg[9];
    endfunction

    function automatic logic [3:0] f_lvl();
        logic [3:0] l;
        l[0] = m_g[m_cfg[1:0]];
        l[1] = m_g[m_cfg[3:2]];
        l[2] = m_g[m_cfg[8:7]];
        l[3] = pt_mode() ? m_pt[m_cfg[12:11]] : ~l[2];
        return l;
    endfunction

    function automatic logic [3:0] f_en();
        logic [3:0] e;
        e[0] = 1'b1;
        e[1] = m_cfg[6] ? m_pt[0] : m_en;
        e[2] = m_cfg[9] ? m_en : 1'b1;
        e[3] = pt_mode() ? 1'b1 : e[2];
        return e;
    endfunction

    function automatic logic [3:0] f_tick(input logic ld_in);
        logic [3:0] l, up, dn, ed;
        l  = f_lvl();
        up = l & ~m_prev;
        dn = ~l & m_prev;
        ed = up;
        if (m_cfg[5:4] == 2'd1)      ed[1] = dn[1];
        else if (m_cfg[5:4] == 2'd2) ed[1] = up[1] | dn[1];
        return (ld_in || m_ld) ? 4'b0 : (ed & f_en());
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg <= '0; m_g <= '0; m_pt <= '0; m_en <= 1'b0;
            m_prev <= 4'b1000; m_ld <= 1'b0; m_cap <= '0;
        end else begin
            logic [3:0] t;
            t = f_tick(cfg_load_i);
            for (int i = 0; i < 4; i++) if (t[i]) m_cap[i*DW +: DW] <= tst_data_i;
            m_prev <= f_lvl();
            m_ld   <= cfg_load_i;
            if (cfg_load_i) m_cfg <= cfg_i;
            m_g  <= gclk_i;
            m_pt <= pterm_i;
            m_en <= clk_en_i;
        end
    end

    function automatic string line_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return pt_mode() ? "R7" : "R6";
        endcase
    endfunction

    task automatic check_all();
        logic [3:0] el, ee, et;
        el = f_lvl();
        ee = f_en();
        et = f_tick(cfg_load_i);
        for (int i = 0; i < 4; i++) begin
            chk(line_lvl_o[i] == el[i], {line_tag(i), " level"}, 32'(line_lvl_o[i]), 32'(el[i]));
            chk(line_en_o[i] == ee[i], {(i == 1) ? "R4" : line_tag(i), " enable"}, 32'(line_en_o[i]), 32'(ee[i]));
            chk(line_tick_o[i] == et[i], {(cfg_load_i || m_ld) ? "R1" : line_tag(i), " tick"},
                32'(line_tick_o[i]), 32'(et[i]));
        end
        chk(cap_o == m_cap, "R9 capture lanes", 32'(cap_o), 32'(m_cap));
        chk(cfg_err_o == (m_cfg[10] & m_cfg[9]), "R8 error flag", 32'(cfg_err_o), 32'(m_cfg[10] & m_cfg[9]));
    endtask

    task automatic drive_rand(input bit keep_cfg);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gclk_i     = gclk_i ^ lfsr[3:0];
        pterm_i    = lfsr[7:4] ^ lfsr[11:8];
        clk_en_i   = lfsr[12] | lfsr[2];
        tst_data_i = lfsr[15:12] ^ lfsr[5:2];
        if (!keep_cfg) cfg_i = {lfsr[12:0]};   // must be ignored while load is low (R1)
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(cap_o == '0, "R10 cap", 32'(cap_o), 32'h0);
        chk(cfg_err_o == 1'b0, "R10 err", 32'(cfg_err_o), 32'h0);
        chk(line_lvl_o == 4'b1000, "R10 levels", 32'(line_lvl_o), 32'h8);
        chk(line_en_o == 4'b1101, "R10 enables", 32'(line_en_o), 32'hd);
        chk(line_tick_o == 4'b0000, "R10 ticks", 32'(line_tick_o), 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 128; c++) begin
            logic [1:0] s, md;
            logic [12:0] v;
            s  = 2'(c % 4);
            md = 2'((c / 4) % 4);
            v = '0;
            v[1:0]   = s;
            v[3:2]   = s + 2'd1;
            v[5:4]   = md;
            v[6]     = c[4];
            v[8:7]   = s + 2'd2;
            v[9]     = c[5];
            v[10]    = c[6];
            v[12:11] = s + 2'd3;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check_all();
                drive_rand(1'b1);
                cfg_load_i = (k < 2);
                cfg_i = v;
            end
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                check_all();
                drive_rand(1'b0);
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule